// File: doc/BRIEF.md
# Eight-Source Interrupt Enable Controller

This block gathers interrupt requests from eight sources: two external pins, four timers, an A/D converter and a serial port. Each request pulse sets a sticky flag. The block keeps a global interrupt-enable bit and two 4-bit enable registers, which the CPU loads from its 4-bit accumulator and reads back into it. When a source is fully qualified, the controller raises an interrupt toward the CPU sequencer after a fixed delay of machine cycles. The interrupt carries a 3-bit source index chosen by fixed priority.

Polling is the second way to service a source. A skip-if-request query on a source returns its flag and clears it, but only while that source's interrupt is disabled. Once a source is enabled, polling it never skips and leaves its flag as it was.

Source index order, which is also the priority order with the highest priority first: 0 external 0, 1 external 1, 2 timer 1, 3 timer 2, 4 timer 3, 5 timer 4, 6 A/D, 7 serial I/O.

Top module: `irqc_top`

## Requirements
- R1: Enable register A holds bit 0 for external 0, bit 1 for external 1, bit 2 for timer 1 and bit 3 for timer 2. A cycle with `ena_wr` loads `acc_in` into it. A cycle with `ena_rd` presents the value held before that edge on `acc_out` in the next cycle. `acc_out` is 0 after a cycle with no read strobe. If both read strobes are high, register A is read.
- R2: Enable register B holds bit 0 for timer 3, bit 1 for timer 4, bit 2 for A/D and bit 3 for serial I/O. It is written with `enb_wr` and read with `enb_rd`, with the same timing as R1.
- R3: Reset and `lp_restore` both clear the two enable registers to 0000. `lp_restore` wins over a write in the same cycle. After reset, all outputs are 0.
- R4: A one-cycle pulse on `req[i]` sets request flag i, and the flag stays set until it is cleared by a poll or an acknowledge.
- R5: A source qualifies only when the global enable, its enable bit and its request flag are all 1. No interrupt is raised otherwise.
- R6: If a qualification starts in cycle T with `multi_cyc` low in T, `irq` rises in cycle T+2, provided some source stays qualified in T+1.
- R7: If `multi_cyc` is high in cycle T, `irq` rises in cycle T+3 instead.
- R8: A cycle with `poll` for source `poll_src` whose enable bit is 0 gives `poll_skip`=1 in the next cycle if its flag was set, and clears that flag. If the enable bit is 1, `poll_skip` is 0 and the flag is left unchanged.
- R9: `irq` stays high until `irq_ack`. An acknowledge drops `irq` in the next cycle, clears the flag of the serviced source and clears the global enable.
- R10: When several sources qualify, `irq_src` gives the lowest source index among them, sampled in the cycle before `irq` rises.
- R11: A request pulse in the same cycle as a clear of that flag (by poll or acknowledge) leaves the flag set.
- R12: `gie_set` sets the global enable and `gie_clr` clears it. `gie_clr` wins if both strobes are high, and reset clears it.
- R13: If no source qualifies during the waiting cycles, the pending interrupt is dropped and `irq` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_restore | input | 1 | Return from low-power back-up; clears enable registers |
| req | input | 8 | Request pulses, one per source index |
| acc_in | input | 4 | Accumulator value for enable writes |
| ena_wr | input | 1 | Write strobe, enable register A |
| enb_wr | input | 1 | Write strobe, enable register B |
| ena_rd | input | 1 | Read strobe, enable register A |
| enb_rd | input | 1 | Read strobe, enable register B |
| acc_out | output | 4 | Registered read-back value |
| gie_set | input | 1 | Set global interrupt enable |
| gie_clr | input | 1 | Clear global interrupt enable |
| multi_cyc | input | 1 | Current cycle belongs to a multi-cycle instruction |
| poll | input | 1 | Skip-if-request query strobe |
| poll_src | input | 3 | Source index being polled |
| poll_skip | output | 1 | Query result: skip taken |
| irq_ack | input | 1 | Sequencer has taken the interrupt |
| irq | output | 1 | Interrupt to the sequencer |
| irq_src | output | 3 | Index of the source being serviced |

## Verification
A wrong flag bit does not stay hidden for long. A poll of that source while it is disabled returns it one cycle later on `poll_skip`. If the source is enabled, it changes `irq`/`irq_src` two or three cycles later. A corrupted enable bit appears on `acc_out` one cycle after a read strobe. It also changes whether a poll skips, and whether the interrupt fires. A miscounted latency or a stuck global enable moves the rising edge of `irq` by a cycle or suppresses it. The bench compares all four outputs with a behavioural model on every cycle, so any of these shows up in the first cycle where the output differs.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_SRC = 8;
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int REG_W   = 4;
  localparam int NUM_REG = NUM_SRC / REG_W;
  localparam int CNT_W   = 2;

  typedef logic [SRC_W-1:0] src_idx_t;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_t;
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flag[i] <= 1'b0;
      else if (req[i])
        flag[i] <= 1'b1;       // a new request beats a clear in the same cycle
      else if (clr[i])
        flag[i] <= 1'b0;
    end

    a_r11_req_wins: assert property (@(posedge clk) disable iff (rst)
      req[i] |=> flag[i]);
    a_r4_flag_holds: assert property (@(posedge clk) disable iff (rst)
      (flag[i] && !clr[i]) |=> flag[i]);
  end
endmodule

// File: rtl/irqc_enable_regs.sv
module irqc_enable_regs #(
  parameter int W  = 4,
  parameter int NB = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restore,
  input  logic [W-1:0]    acc_in,
  input  logic [NB-1:0]   wr,
  input  logic [NB-1:0]   rd,
  output logic [NB*W-1:0] en_vec,
  output logic [W-1:0]    acc_out
);
  logic [W-1:0] bank [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst || restore)
        bank[b] <= '0;
      else if (wr[b])
        bank[b] <= acc_in;
    end
    assign en_vec[b*W +: W] = bank[b];

    a_r3_restore_clears: assert property (@(posedge clk) disable iff (rst)
      restore |=> (bank[b] == '0));
  end

  logic [W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int b = NB - 1; b >= 0; b--)
      if (rd[b]) rd_mux = bank[b];
  end

  always_ff @(posedge clk) begin
    if (rst) acc_out <= '0;
    else     acc_out <= rd_mux;
  end

  a_r1_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd == '0) |=> (acc_out == '0));
endmodule

// File: rtl/irqc_prio_sel.sv
module irqc_prio_sel #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  qual,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (qual[i]) idx = IW'(i);
  end
  assign any = |qual;
endmodule

// File: rtl/irqc_latency_seq.sv
module irqc_latency_seq
  import irqc_pkg::*;
#(
  parameter int IW = SRC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any_qual,
  input  logic [IW-1:0] sel_idx,
  input  logic          multi,
  input  logic          ack,
  output logic          irq,
  output logic [IW-1:0] irq_src,
  output logic          ack_fire
);
  seq_state_t       st;
  logic [CNT_W-1:0] cnt;

  assign ack_fire = ack && irq;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SEQ_IDLE;
      cnt     <= '0;
      irq     <= 1'b0;
      irq_src <= '0;
    end else if (irq) begin
      if (ack) begin
        irq <= 1'b0;
        st  <= SEQ_IDLE;
      end
    end else begin
      case (st)
        SEQ_IDLE: if (any_qual) begin
          st  <= SEQ_WAIT;
          cnt <= multi ? CNT_W'(1) : CNT_W'(0);
        end
        SEQ_WAIT: begin
          if (!any_qual)
            st <= SEQ_IDLE;
          else if (cnt == '0) begin
            irq     <= 1'b1;
            irq_src <= sel_idx;
            st      <= SEQ_IDLE;
          end else
            cnt <= cnt - 1'b1;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  a_r9_ack_drops: assert property (@(posedge clk) disable iff (rst)
    (ack && irq) |=> !irq);
  a_r9_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack) |=> (irq && $stable(irq_src)));
  a_r13_cancel: assert property (@(posedge clk) disable iff (rst)
    (!irq && st == SEQ_WAIT && !any_qual) |=> !irq);
  a_r6_no_instant: assert property (@(posedge clk) disable iff (rst)
    (!irq && st == SEQ_IDLE) |=> !irq);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               lp_restore,
  input  logic [NUM_SRC-1:0] req,
  input  logic [REG_W-1:0]   acc_in,
  input  logic               ena_wr,
  input  logic               enb_wr,
  input  logic               ena_rd,
  input  logic               enb_rd,
  output logic [REG_W-1:0]   acc_out,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               multi_cyc,
  input  logic               poll,
  input  logic [SRC_W-1:0]   poll_src,
  output logic               poll_skip,
  input  logic               irq_ack,
  output logic               irq,
  output logic [SRC_W-1:0]   irq_src
);
  logic [NUM_SRC-1:0] en_vec, flag, clr, qual;
  logic               gie, any_qual, ack_fire, poll_hit;
  src_idx_t           sel_idx;

  irqc_enable_regs #(.W(REG_W), .NB(NUM_REG)) u_en (
    .clk(clk), .rst(rst), .restore(lp_restore), .acc_in(acc_in),
    .wr({enb_wr, ena_wr}), .rd({enb_rd, ena_rd}),
    .en_vec(en_vec), .acc_out(acc_out)
  );

  irqc_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst(rst), .req(req), .clr(clr), .flag(flag)
  );

  assign qual = flag & en_vec & {NUM_SRC{gie}};

  irqc_prio_sel #(.N(NUM_SRC), .IW(SRC_W)) u_prio (
    .qual(qual), .any(any_qual), .idx(sel_idx)
  );

  irqc_latency_seq #(.IW(SRC_W)) u_seq (
    .clk(clk), .rst(rst), .any_qual(any_qual), .sel_idx(sel_idx),
    .multi(multi_cyc), .ack(irq_ack), .irq(irq), .irq_src(irq_src),
    .ack_fire(ack_fire)
  );

  // polling is honoured only for a source whose interrupt is disabled
  assign poll_hit = poll && !en_vec[poll_src] && flag[poll_src];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign clr[i] = (ack_fire && irq_src == SRC_W'(i)) ||
                    (poll_hit && poll_src == SRC_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gie       <= 1'b0;
      poll_skip <= 1'b0;
    end else begin
      poll_skip <= poll_hit;
      if (gie_clr || ack_fire) gie <= 1'b0;
      else if (gie_set)        gie <= 1'b1;
    end
  end

  a_r12_clr_wins: assert property (@(posedge clk) disable iff (rst)
    gie_clr |=> !gie);
  a_r9_ack_clears_gie: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq) |=> !gie);
  a_r5_rise_needs_gie: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(gie));
  a_r8_enabled_no_skip: assert property (@(posedge clk) disable iff (rst)
    (poll && en_vec[poll_src]) |=> !poll_skip);
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  logic       clk = 1'b0;
  logic       rst, lp_restore, ena_wr, enb_wr, ena_rd, enb_rd;
  logic       gie_set, gie_clr, multi_cyc, poll, irq_ack;
  logic [7:0] req;
  logic [3:0] acc_in;
  logic [2:0] poll_src;
  logic [3:0] acc_out;
  logic       poll_skip, irq;
  logic [2:0] irq_src;

  always #5 clk = ~clk;

  irqc_top u_dut (
    .clk(clk), .rst(rst), .lp_restore(lp_restore), .req(req),
    .acc_in(acc_in), .ena_wr(ena_wr), .enb_wr(enb_wr), .ena_rd(ena_rd),
    .enb_rd(enb_rd), .acc_out(acc_out), .gie_set(gie_set),
    .gie_clr(gie_clr), .multi_cyc(multi_cyc), .poll(poll),
    .poll_src(poll_src), .poll_skip(poll_skip), .irq_ack(irq_ack),
    .irq(irq), .irq_src(irq_src)
  );

  // behavioural reference
  bit     m_flag [8];
  int     m_ena, m_enb, m_acc, m_src, m_cnt;
  bit     m_gie, m_skip, m_irq, m_wait;
  int     total = 0, bad = 0;
  bit     done = 0;
  string  tag = "R3";

  function automatic bit en_of(int s);
    return s < 4 ? m_ena[s] : m_enb[s-4];
  endfunction

  task automatic model_step();
    bit q_any, fire, hit;
    int sel, ps;
    q_any = 0; sel = 0;
    for (int i = 7; i >= 0; i--)
      if (m_gie && en_of(i) && m_flag[i]) begin q_any = 1; sel = i; end
    if (rst) begin
      foreach (m_flag[i]) m_flag[i] = 0;
      m_ena = 0; m_enb = 0; m_acc = 0; m_src = 0; m_cnt = 0;
      m_gie = 0; m_skip = 0; m_irq = 0; m_wait = 0;
      return;
    end
    fire = irq_ack && m_irq;
    ps   = int'(poll_src);
    hit  = poll && !en_of(ps) && m_flag[ps];
    m_acc = ena_rd ? m_ena : (enb_rd ? m_enb : 0);
    m_skip = hit;
    if (fire) m_flag[m_src] = 0;
    if (hit)  m_flag[ps] = 0;
    for (int i = 0; i < 8; i++) if (req[i]) m_flag[i] = 1;
    if (fire || gie_clr) m_gie = 0; else if (gie_set) m_gie = 1;
    if (lp_restore) begin m_ena = 0; m_enb = 0; end
    else begin
      if (ena_wr) m_ena = int'(acc_in);
      if (enb_wr) m_enb = int'(acc_in);
    end
    if (m_irq) begin
      if (irq_ack) begin m_irq = 0; m_wait = 0; end
    end else if (!m_wait) begin
      if (q_any) begin m_wait = 1; m_cnt = multi_cyc ? 1 : 0; end
    end else begin
      if (!q_any) m_wait = 0;
      else if (m_cnt == 0) begin m_irq = 1; m_src = sel; m_wait = 0; end
      else m_cnt--;
    end
  endtask

  task automatic chk(string r, string nm, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", r, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(tag == "R3" ? "R3" : "R1", "acc_out", int'(acc_out), m_acc);
    chk(tag == "R11" ? "R11" : "R8", "poll_skip", int'(poll_skip), int'(m_skip));
    chk(tag, "irq", int'(irq), int'(m_irq));
    if (m_irq) chk("R10", "irq_src", int'(irq_src), m_src);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    lp_restore = 0; ena_wr = 0; enb_wr = 0; ena_rd = 0; enb_rd = 0;
    gie_set = 0; gie_clr = 0; poll = 0; irq_ack = 0; req = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wait_irq_ack();
    for (int i = 0; i < 8 && !irq; i++) cyc();
    irq_ack = 1; cyc();
  endtask

  initial begin
    rst = 1; lp_restore = 0; ena_wr = 0; enb_wr = 0; ena_rd = 0; enb_rd = 0;
    gie_set = 0; gie_clr = 0; multi_cyc = 0; poll = 0; irq_ack = 0;
    req = '0; acc_in = '0; poll_src = '0;
    @(negedge clk);
    idle(2);
    rst = 0;
    tag = "R3"; idle(1);
    // R1 / R2 register write and read-back
    tag = "R1"; acc_in = 4'hA; ena_wr = 1; cyc(); ena_rd = 1; cyc(); idle(1);
    tag = "R2"; acc_in = 4'h5; enb_wr = 1; cyc(); enb_rd = 1; cyc();
    ena_rd = 1; enb_rd = 1; cyc();
    // R3 restore clears and beats a write
    tag = "R3"; lp_restore = 1; acc_in = 4'hF; ena_wr = 1; cyc();
    ena_rd = 1; cyc(); enb_rd = 1; cyc();
    // R4 / R8 poll with source disabled: timer 2 is index 3
    tag = "R4"; req[3] = 1; cyc(); idle(2);
    poll = 1; poll_src = 3'd3; cyc(); poll = 1; cyc();
    // R8 poll while enabled: no skip, flag kept
    tag = "R8"; acc_in = 4'b1000; ena_wr = 1; req[3] = 1; cyc();
    poll = 1; poll_src = 3'd3; cyc(); idle(1);
    acc_in = 4'b0000; ena_wr = 1; cyc(); poll = 1; cyc(); idle(1);
    // R5 enable+flag without global enable: no interrupt
    tag = "R5"; acc_in = 4'b0001; ena_wr = 1; req[0] = 1; cyc(); idle(5);
    // R6 set global enable: latency two cycles
    tag = "R6"; gie_set = 1; cyc(); wait_irq_ack(); idle(2);
    // R7 multi-cycle instruction at the qualifying cycle
    tag = "R7"; multi_cyc = 1; req[0] = 1; gie_set = 1; cyc(); wait_irq_ack();
    multi_cyc = 0; idle(2);
    // R10 priority: timer 1 (2) over timer 4 (5)
    tag = "R10"; acc_in = 4'b0100; ena_wr = 1; cyc();
    acc_in = 4'b0010; enb_wr = 1; cyc();
    req[2] = 1; req[5] = 1; gie_set = 1; cyc(); wait_irq_ack();
    gie_set = 1; cyc(); wait_irq_ack(); idle(1);
    // R11 request in the same cycle as a poll clear
    tag = "R11"; lp_restore = 1; cyc(); req[6] = 1; cyc();
    poll = 1; poll_src = 3'd6; req[6] = 1; cyc(); poll = 1; cyc(); idle(1);
    // R9 acknowledge with a new pulse on the serviced source
    tag = "R9"; acc_in = 4'b0001; ena_wr = 1; req[0] = 1; gie_set = 1; cyc();
    for (int i = 0; i < 6 && !irq; i++) cyc();
    irq_ack = 1; req[0] = 1; cyc(); idle(2); gie_set = 1; cyc(); wait_irq_ack();
    // R13 qualification lost while waiting
    tag = "R13"; req[0] = 1; cyc(); gie_set = 1; cyc(); gie_clr = 1; cyc(); idle(4);
    // R12 set and clear together: clear wins
    tag = "R12"; gie_set = 1; gie_clr = 1; cyc(); idle(4);
    gie_set = 1; cyc(); wait_irq_ack();
    // mixed stimulus
    tag = "R6";
    for (int n = 0; n < 400; n++) begin
      req = ($urandom % 6 == 0) ? 8'(1 << ($urandom % 8)) : '0;
      acc_in = 4'($urandom); multi_cyc = 1'($urandom % 3 == 0);
      ena_wr = 1'($urandom % 12 == 0); enb_wr = 1'($urandom % 12 == 0);
      ena_rd = 1'($urandom % 5 == 0); enb_rd = 1'($urandom % 5 == 0);
      gie_set = 1'($urandom % 6 == 0); gie_clr = 1'($urandom % 20 == 0);
      poll = 1'($urandom % 4 == 0); poll_src = 3'($urandom);
      lp_restore = 1'($urandom % 60 == 0); irq_ack = irq && ($urandom % 2 == 0);
      cyc();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule